// File: doc/BRIEF.md
# Desaturation Fault Latch with Qualified Reset

This block sits on the output side of an isolated gate driver. It decides when the power switch may be on and when a short-circuit trip must shut it down. A desaturation comparator flag is synchronised and counts as a trip only while the gate is actually on and the external blanking comparator reports that the blanking time has run out. A trip latches a fault. The latched fault holds the gate off whatever the gate command is, and an active-low fault indication follows after a programmable number of cycles.

One active-low control pin does two jobs. As an enable, a low level turns the gate off. Low pulses shorter than a glitch window are filtered out. As a fault clear, the pin removes a latched fault on its rising edge, but only if it stayed low for at least a minimum number of cycles. Shorter pulses leave the fault in place. An undervoltage flag from the supply monitor also forces the gate off. Each turn-on of the gate sends a one-cycle restart pulse to the blanking timer.

Top module: `desat_guard`

## Requirements
- R1: After reset, gate_out is 0, fault_n is 1 and blank_restart is 0, with no fault latched and the enable inactive.
- R2: With the enable active, no fault latched and uv_err low, gate_out equals the gate_cmd value sampled at the previous clock edge.
- R3: blank_restart is 1 in exactly the first cycle of each high period of gate_out, and 0 in every other cycle.
- R4: desat_trip passes through two flip-flops. A fault latches only when the synchronised trip is 1, gate_out is 1 and blank_done is 1. A trip while blank_done is 0 or gate_out is 0 is ignored.
- R5: A trip driven before a clock edge k turns gate_out to 0 after edge k+2. While the fault is latched, gate_out stays 0 even with gate_cmd at 1.
- R6: fault_n goes to 0 exactly FLT_DLY_CYC cycles after gate_out was forced to 0 by a trip, and stays 0 until the fault is cleared.
- R7: A latched fault clears only when rstb_pin rises after a low period of at least MIN_RST_CYC sampled cycles, and fault_n then returns to 1. A shorter low period leaves fault_n and the fault unchanged.
- R8: rstb_pin held low for GLITCH_CYC or more consecutive sampled cycles forces gate_out to 0. Shorter low pulses have no effect on gate_out.
- R9: While uv_err is 1, gate_out is 0 from the next clock edge on. It follows gate_cmd again after uv_err returns to 0.
- R10: A qualifying low pulse on rstb_pin while no fault is latched leaves fault_n at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| desat_trip | input | 1 | Desaturation comparator flag, asynchronous |
| gate_cmd | input | 1 | Requested gate state, 1 = on |
| blank_done | input | 1 | Blanking timer comparator, 1 = blanking expired |
| uv_err | input | 1 | Undervoltage error, 1 = supply too low |
| rstb_pin | input | 1 | Active-low enable and fault-clear pin, asynchronous |
| gate_out | output | 1 | Gate drive command, 1 = on |
| blank_restart | output | 1 | One-cycle pulse restarting blanking on each turn-on |
| fault_n | output | 1 | Active-low fault indication |

## Verification
A fault state that wrongly stays latched or clears too early shows up at the ports within a few cycles. gate_out either refuses to follow gate_cmd or comes back after a reset pulse that was too short, and fault_n shows the same state after the programmed delay. A wrong delay counter moves the falling edge of fault_n relative to the falling edge of gate_out, so the bench measures that distance in cycles. A wrong enable filter or a wrong pulse-width counter becomes visible by sweeping the pulse length through each threshold and watching gate_out and fault_n in the cycles after the pulse ends.

// File: rtl/desat_pkg.sv
package desat_pkg;
  // fault latch states
  typedef enum logic [1:0] {
    FS_IDLE   = 2'b00,  // no fault
    FS_PEND   = 2'b01,  // fault latched, indication delay running
    FS_SHOWN  = 2'b10   // fault latched and indicated
  } flt_state_e;

  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/desat_sync.sv
module desat_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0] chain_q [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_d;
    always_comb begin
      chain_d = {chain_q[b][STAGES-2:0], d_i[b]};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[b] <= '0;
      else        chain_q[b] <= chain_d;
    end
    assign q_o[b] = chain_q[b][STAGES-1];
  end
endmodule

// File: rtl/desat_pin_qual.sv
module desat_pin_qual
  import desat_pkg::*;
#(
  parameter int GLITCH_CYC  = 4,
  parameter int MIN_RST_CYC = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,     // synchronised active-low pin
  output logic en_o,      // filtered enable, 1 = enabled
  output logic clr_o      // one-cycle fault clear request
);
  localparam int GW = cnt_w(GLITCH_CYC);
  localparam int LW = cnt_w(MIN_RST_CYC);
  localparam logic [GW-1:0] G_LAST = GW'(GLITCH_CYC - 1);
  localparam logic [LW-1:0] L_MAX  = LW'(MIN_RST_CYC);

  logic          en_q, en_d;
  logic [GW-1:0] g_cnt_q, g_cnt_d;
  logic [LW-1:0] low_q, low_d;
  logic          g_ce, l_ce;

  // glitch filter: level must differ for GLITCH_CYC cycles to flip enable
  always_comb begin
    en_d    = en_q;
    g_cnt_d = g_cnt_q;
    g_ce    = 1'b0;
    if (pin_s == en_q) begin
      g_cnt_d = '0;
      g_ce    = (g_cnt_q != '0);
    end else begin
      g_ce = 1'b1;
      if (g_cnt_q == G_LAST) begin
        en_d    = pin_s;
        g_cnt_d = '0;
      end else begin
        g_cnt_d = g_cnt_q + 1'b1;
      end
    end
  end

  // low-width counter, saturating at the qualifying width
  always_comb begin
    low_d = low_q;
    l_ce  = 1'b0;
    if (pin_s) begin
      low_d = '0;
      l_ce  = (low_q != '0);
    end else if (low_q != L_MAX) begin
      low_d = low_q + 1'b1;
      l_ce  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      g_cnt_q <= '0;
    end else if (g_ce) begin
      en_q    <= en_d;
      g_cnt_q <= g_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    low_q <= '0;
    else if (l_ce) low_q <= low_d;
  end

  assign en_o  = en_q;
  assign clr_o = pin_s && (low_q == L_MAX);

  // R8: the enable only ever takes the level the pin showed one cycle before
  a_r8_en_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> (en_q == $past(pin_s)));
  // R7: a clear request lasts a single cycle
  a_r7_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |=> !clr_o);
endmodule

// File: rtl/desat_fault_latch.sv
module desat_fault_latch
  import desat_pkg::*;
#(
  parameter int FLT_DLY_CYC = 225
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_s,
  input  logic gate_on,
  input  logic blank_done,
  input  logic clr_i,
  output logic fault_next_o,  // fault state after this edge
  output logic fault_n_o
);
  localparam int DW = cnt_w(FLT_DLY_CYC);
  localparam logic [DW-1:0] D_LAST = DW'(FLT_DLY_CYC - 1);

  flt_state_e    st_q, st_d;
  logic [DW-1:0] dly_q, dly_d;
  logic          trip_ok;
  logic          d_ce;

  assign trip_ok = trip_s && gate_on && blank_done;

  always_comb begin
    st_d  = st_q;
    dly_d = dly_q;
    d_ce  = 1'b0;
    unique case (st_q)
      FS_IDLE: begin
        if (trip_ok) begin
          st_d  = FS_PEND;
          dly_d = '0;
          d_ce  = 1'b1;
        end
      end
      FS_PEND: begin
        if (clr_i) begin
          st_d = FS_IDLE;
        end else if (dly_q == D_LAST) begin
          st_d = FS_SHOWN;
        end else begin
          dly_d = dly_q + 1'b1;
          d_ce  = 1'b1;
        end
      end
      FS_SHOWN: begin
        if (clr_i) st_d = FS_IDLE;
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dly_q <= '0;
    else if (d_ce) dly_q <= dly_d;
  end

  assign fault_next_o = (st_d != FS_IDLE);
  assign fault_n_o    = (st_q != FS_SHOWN);

  // R7: a latched fault leaves only through a clear request
  a_r7_hold_without_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != FS_IDLE) && !clr_i |=> (st_q != FS_IDLE));
  // R4: a fault is entered only with the gate on and blanking expired
  a_r4_entry_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_IDLE) && !(gate_on && blank_done) |=> (st_q == FS_IDLE));
endmodule

// File: rtl/desat_gate_ctl.sv
module desat_gate_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  input  logic en_i,
  input  logic fault_i,
  input  logic uv_i,
  output logic gate_o,
  output logic blank_o
);
  logic gate_q, gate_d;
  logic blank_q, blank_d;

  always_comb begin
    gate_d  = cmd_i && en_i && !fault_i && !uv_i;
    blank_d = gate_d && !gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      gate_q  <= gate_d;
      blank_q <= blank_d;
    end
  end

  assign gate_o  = gate_q;
  assign blank_o = blank_q;

  // R8: a disabled pin turns the gate off at the next edge
  a_r8_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !gate_q);
  // R9: undervoltage turns the gate off at the next edge
  a_r9_off_in_uv: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> !gate_q);
endmodule

// File: rtl/desat_guard.sv
module desat_guard
  import desat_pkg::*;
#(
  parameter int FLT_DLY_CYC = 225,
  parameter int MIN_RST_CYC = 80,
  parameter int GLITCH_CYC  = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic desat_trip,
  input  logic gate_cmd,
  input  logic blank_done,
  input  logic uv_err,
  input  logic rstb_pin,
  output logic gate_out,
  output logic blank_restart,
  output logic fault_n
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  logic [1:0] raw_in, syn_out;
  logic       trip_s, pin_s;
  logic       en, clr, fault_next;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign raw_in = {rstb_pin, desat_trip};
  desat_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .d_i(raw_in), .q_o(syn_out)
  );
  assign trip_s = syn_out[0];
  assign pin_s  = syn_out[1];

  desat_pin_qual #(.GLITCH_CYC(GLITCH_CYC), .MIN_RST_CYC(MIN_RST_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n_i), .pin_s(pin_s), .en_o(en), .clr_o(clr)
  );

  desat_fault_latch #(.FLT_DLY_CYC(FLT_DLY_CYC)) u_latch (
    .clk(clk), .rst_n(rst_n_i), .trip_s(trip_s), .gate_on(gate_out),
    .blank_done(blank_done), .clr_i(clr), .fault_next_o(fault_next),
    .fault_n_o(fault_n)
  );

  desat_gate_ctl u_gate (
    .clk(clk), .rst_n(rst_n_i), .cmd_i(gate_cmd), .en_i(en),
    .fault_i(fault_next), .uv_i(uv_err), .gate_o(gate_out),
    .blank_o(blank_restart)
  );

  // R5: an indicated fault never coexists with an on gate
  a_r5_off_while_fault: assert property (@(posedge clk) disable iff (!rst_n_i)
    !fault_n |-> !gate_out);
  // R3: every turn-on carries a blanking restart
  a_r3_restart_on_rise: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(gate_out) |-> blank_restart);
  // R3: no restart while the gate was already on
  a_r3_no_restart_held: assert property (@(posedge clk) disable iff (!rst_n_i)
    $past(gate_out) |-> !blank_restart);
endmodule

// File: tb/tb_desat_guard.sv
module tb_desat_guard;
  localparam int CLK_PER = 10;
  localparam int FD = 5;
  localparam int MR = 8;
  localparam int GC = 3;

  logic clk = 1'b0;
  logic arst_n, desat_trip, gate_cmd, blank_done, uv_err, rstb_pin;
  logic gate_out, blank_restart, fault_n;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  desat_guard #(.FLT_DLY_CYC(FD), .MIN_RST_CYC(MR), .GLITCH_CYC(GC)) dut (
    .clk(clk), .arst_n(arst_n), .desat_trip(desat_trip), .gate_cmd(gate_cmd),
    .blank_done(blank_done), .uv_err(uv_err), .rstb_pin(rstb_pin),
    .gate_out(gate_out), .blank_restart(blank_restart), .fault_n(fault_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bring gate on and trip it; returns cycles to gate off and fault delay
  task automatic make_fault(output int g_at, output int f_dly);
    int g;
    g_at = -1; f_dly = -1;
    desat_trip = 0; gate_cmd = 1; blank_done = 1;
    g = 0;
    while (gate_out !== 1'b1 && g < 40) begin tick(1); g++; end
    desat_trip = 1;
    for (int i = 1; i <= 30; i++) begin
      tick(1);
      if (g_at < 0 && gate_out === 1'b0) g_at = i;
      if (f_dly < 0 && fault_n === 1'b0) begin f_dly = i - g_at; break; end
    end
    desat_trip = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ga, fd;
    arst_n = 0; desat_trip = 0; gate_cmd = 0; blank_done = 0; uv_err = 0; rstb_pin = 1;
    tick(3);
    // R1 reset state
    chk(gate_out === 0, "R1 gate_out", gate_out, 0);
    chk(fault_n === 1, "R1 fault_n", fault_n, 1);
    chk(blank_restart === 0, "R1 blank_restart", blank_restart, 0);
    arst_n = 1;
    tick(12);
    chk(gate_out === 0 && fault_n === 1, "R1 idle after release", {gate_out, fault_n}, 1);

    // R2/R3 gate follows command with one-cycle latency
    for (int rep = 0; rep < 3; rep++) begin
      gate_cmd = 1; tick(1);
      chk(gate_out === 1, "R2 gate on", gate_out, 1);
      chk(blank_restart === 1, "R3 restart on rise", blank_restart, 1);
      tick(1);
      chk(blank_restart === 0, "R3 restart one cycle", blank_restart, 0);
      gate_cmd = 0; tick(1);
      chk(gate_out === 0, "R2 gate off", gate_out, 0);
    end

    // R4 trip ignored while blanking active
    gate_cmd = 1; blank_done = 0; tick(2); desat_trip = 1; tick(15);
    chk(gate_out === 1 && fault_n === 1, "R4 blanking active ignored", {gate_out, fault_n}, 3);
    // R4 trip ignored while gate off
    gate_cmd = 0; tick(1); blank_done = 1; tick(15);
    chk(fault_n === 1, "R4 gate off ignored", fault_n, 1);
    desat_trip = 0; tick(4);
    gate_cmd = 1; tick(2);
    chk(gate_out === 1, "R4 no fault latched", gate_out, 1);

    // R5/R6 valid trip
    make_fault(ga, fd);
    chk(ga == 3, "R5 gate off latency", ga, 3);
    chk(fd == FD, "R6 fault delay", fd, FD);
    tick(10);
    chk(gate_out === 0 && fault_n === 0, "R5 held off with cmd high", {gate_out, fault_n}, 0);

    // R7 reset width sweep
    for (int len = 1; len <= MR + 4; len++) begin
      bit exp_clr;
      bit saw_on;
      if (fault_n !== 1'b0) begin
        make_fault(ga, fd);
        tick(2);
      end
      exp_clr = (len >= MR);
      saw_on = 0;
      rstb_pin = 0;
      for (int i = 0; i < len; i++) begin tick(1); if (gate_out) saw_on = 1; end
      rstb_pin = 1;
      for (int i = 0; i < 5; i++) begin tick(1); if (gate_out && !exp_clr) saw_on = 1; end
      chk(fault_n === exp_clr, $sformatf("R7 width %0d", len), fault_n, exp_clr);
      if (!exp_clr) chk(!saw_on, "R5 gate stays off on short pulse", saw_on, 0);
    end

    // make sure no fault is left, gate on
    if (fault_n === 1'b0) begin
      rstb_pin = 0; tick(MR + 2); rstb_pin = 1; tick(4);
    end
    gate_cmd = 1; tick(GC + 6);
    chk(fault_n === 1 && gate_out === 1, "R7 recovered", {fault_n, gate_out}, 3);

    // R8 glitch sweep with R3 restart per cycle, R10 no fault from long pulses
    for (int len = 1; len <= MR + 2; len++) begin
      bit saw_low, prev, rs_err, f_low;
      saw_low = 0; rs_err = 0; f_low = 0; prev = gate_out;
      rstb_pin = 0;
      for (int i = 0; i < len + GC + 8; i++) begin
        if (i == len) rstb_pin = 1;
        tick(1);
        if (!gate_out) saw_low = 1;
        if (blank_restart !== (gate_out && !prev)) rs_err = 1;
        if (!fault_n) f_low = 1;
        prev = gate_out;
      end
      chk(saw_low == (len >= GC), $sformatf("R8 pulse %0d", len), saw_low, len >= GC);
      chk(!rs_err, "R3 restart pattern", rs_err, 0);
      chk(!f_low, "R10 no fault from pulse", f_low, 0);
      chk(gate_out === 1, "R8 gate back", gate_out, 1);
    end

    // R9 undervoltage
    uv_err = 1; tick(1);
    chk(gate_out === 0, "R9 off in uv", gate_out, 0);
    tick(5);
    chk(gate_out === 0, "R9 held in uv", gate_out, 0);
    uv_err = 0; tick(1);
    chk(gate_out === 1 && blank_restart === 1, "R9 back after uv", {gate_out, blank_restart}, 3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule